// File: doc/BRIEF.md
# Output-Stationary 3x3 Systolic Matrix Multiplier

This block multiplies two 3x3 matrices of signed 8-bit integers on a 3 by 3 grid of multiply-accumulate cells. The cell at row i, column j owns the result C[i][j] and builds it in its own accumulator, so no result ever moves between cells. Left-operand values enter each grid row at its left end and move one cell to the right per step. Right-operand values enter each grid column at its top end and move one cell down per step.

The feed into row i is held back by i steps and the feed into column j by j steps. Because of this skew, cell (i,j) meets the pair a[i][k], b[k][j] at step i+j+k+1. The results therefore complete in anti-diagonal waves, and the whole product is ready at step 7. The same work on one sequential multiply-accumulate unit would take 27 steps.

A single start pulse captures both matrices, clears the grid and begins the run. After the run, all nine results stay on a parallel output bus until the next accepted start.

Top module: `mm3_systolic`

## Requirements
- R1: After reset, busy and done are 0 and all nine result fields of c_out are 0.
- R2: A start pulse seen while busy is 0 captures a_mat and b_mat and clears all accumulators and operand pipeline registers. In the cycle after that edge, busy is 1 and c_out is all zero.
- R3: When the run ends, field (i,j) of c_out holds the signed sum over k of a[i][k]*b[k][j]. Element (i,k) of a_mat sits at bits [(3i+k)*8 +: 8]. Element (k,j) of b_mat sits at bits [(3k+j)*8 +: 8]. Result (i,j) sits at bits [(3i+j)*18 +: 18] of c_out.
- R4: The start pulse is sampled at edge E0 and edge E_s performs step s. done is 1 for exactly the one cycle after E7, and busy falls at E7.
- R5: After edge E_s, field (i,j) holds exactly the sum of the products with k no greater than s-1-i-j. So C00 is final after step 3, C01 and C10 after step 4, C02, C11 and C20 after step 5, C12 and C21 after step 6, and C22 after step 7.
- R6: While idle, c_out stays unchanged whatever a_mat and b_mat do, until the next accepted start.
- R7: A start pulse that arrives while busy is 1 is ignored. The run keeps its timing and its captured operands.
- R8: Skew bubbles and steps after the last k inject zero, so full-scale operands (-128 and 127) give exact 18-bit results with no stray products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| a_mat | input | 72 | Left matrix, nine signed 8-bit elements |
| b_mat | input | 72 | Right matrix, nine signed 8-bit elements |
| busy | output | 1 | High during the seven computation steps |
| done | output | 1 | One-cycle pulse when all results are final |
| c_out | output | 162 | Nine signed 18-bit results |

## Verification
The assertions assume that start is a synchronous level sampled at rising edges, and that the inputs carry no unknown values once reset is released. They also assume that a_mat and b_mat only matter in the cycle where a start is accepted. The bench drives every input on the falling edge, keeps start high for exactly one cycle, and deliberately changes the matrices while the block is busy or idle to show that those changes are ignored. Results are sampled on falling edges after each step, so the partial sums of each anti-diagonal wave are compared at every step.

// File: rtl/mm3_systolic.sv
module mm3_systolic #(
  parameter int DW = 8,
  parameter int AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [9*DW-1:0]   a_mat,
  input  logic [9*DW-1:0]   b_mat,
  output logic              busy,
  output logic              done,
  output logic [9*AW-1:0]   c_out
);
  localparam int N     = 3;
  localparam int LAST  = 3 * N - 2;
  localparam int PW    = 2 * DW;

  logic signed [DW-1:0] am  [N][N];
  logic signed [DW-1:0] bm  [N][N];
  logic signed [DW-1:0] ap  [N][N-1];
  logic signed [DW-1:0] bp  [N-1][N];
  logic signed [DW-1:0] ain [N];
  logic signed [DW-1:0] bin [N];
  logic signed [DW-1:0] aop [N][N];
  logic signed [DW-1:0] bop [N][N];
  logic signed [PW-1:0] prd [N][N];
  logic signed [AW-1:0] acc [N][N];
  logic [3:0] stp;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ain[i] = '0;
      bin[i] = '0;
      for (int k = 0; k < N; k++) begin
        if (busy && stp == 4'(i + k + 1)) begin
          ain[i] = am[i][k];
          bin[i] = bm[k][i];
        end
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      if (gj == 0) begin : g_ledge
        assign aop[gi][gj] = ain[gi];
      end else begin : g_linner
        assign aop[gi][gj] = ap[gi][gj-1];
      end
      if (gi == 0) begin : g_tedge
        assign bop[gi][gj] = bin[gj];
      end else begin : g_tinner
        assign bop[gi][gj] = bp[gi-1][gj];
      end
      assign prd[gi][gj] = aop[gi][gj] * bop[gi][gj];
      assign c_out[(gi*N+gj)*AW +: AW] = acc[gi][gj];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      stp  <= '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          am[i][j]  <= '0;
          bm[i][j]  <= '0;
          acc[i][j] <= '0;
        end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N-1; j++) begin
          ap[i][j] <= '0;
          bp[j][i] <= '0;
        end
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        stp  <= 4'd1;
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) begin
            am[i][j]  <= a_mat[(i*N+j)*DW +: DW];
            bm[i][j]  <= b_mat[(i*N+j)*DW +: DW];
            acc[i][j] <= '0;
          end
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N-1; j++) begin
            ap[i][j] <= '0;
            bp[j][i] <= '0;
          end
      end else if (busy) begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            acc[i][j] <= acc[i][j] + {{(AW-PW){prd[i][j][PW-1]}}, prd[i][j]};
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N-1; j++) begin
            ap[i][j] <= aop[i][j];
            bp[j][i] <= bop[j][i];
          end
        if (stp == 4'(LAST)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          stp <= stp + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/mm3_systolic_chk.sv
module mm3_systolic_chk #(
  parameter int AW = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [9*AW-1:0] c_out
);
  logic [3:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (start && !busy)  cnt <= 4'd1;
    else if (busy)            cnt <= cnt + 4'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == 4'd8 && !busy)); // R4
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && c_out == '0)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!busy) && !busy) |-> $stable(c_out)); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt < 4'd7) |=> (busy && cnt != 4'd1)); // R7
endmodule

bind mm3_systolic mm3_systolic_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .c_out(c_out)
);

// File: tb/mm3_systolic_tb.sv
module mm3_systolic_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [71:0]  a_mat = '0;
  logic [71:0]  b_mat = '0;
  logic         busy, done;
  logic [161:0] c_out;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mm3_systolic u_dut (.clk(clk), .rst_n(rst_n), .start(start), .a_mat(a_mat),
                      .b_mat(b_mat), .busy(busy), .done(done), .c_out(c_out));

  localparam int NV = 5;
  localparam logic [71:0] VA [NV] = '{
    72'h010000000100000001, 72'hFD05F902FF0A03FE07, 72'h808080808080808080,
    72'h7F807F807F807F807F, 72'h0300FE00010200FF04 };
  localparam logic [71:0] VB [NV] = '{
    72'h090807060504030201, 72'h04FB0609F80103FA02, 72'h808080808080808080,
    72'h80807F7F80807F7F80, 72'h0102030405060708F9 };

  function automatic logic [161:0] expect_at(input logic [71:0] a, input logic [71:0] b,
                                             input int s);
    logic [161:0] r = '0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        logic signed [17:0] sum = '0;
        for (int k = 0; k < 3; k++)
          if (i + j + k + 1 <= s)
            sum += 18'(signed'(a[(i*3+k)*8 +: 8])) * 18'(signed'(b[(k*3+j)*8 +: 8]));
        r[(i*3+j)*18 +: 18] = sum;
      end
    return r;
  endfunction

  task automatic chk(input string req, input logic [161:0] act, input logic [161:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [71:0] a, input logic [71:0] b, input int intr);
    logic [161:0] fin;
    @(negedge clk); a_mat = a; b_mat = b; start = 1'b1;
    @(negedge clk); start = 1'b0; a_mat = ~a;
    chk("R2 busy", 162'(busy), 162'd1);
    chk("R2 cleared", c_out, '0);
    for (int s = 1; s <= 7; s++) begin
      if (s == intr) begin start = 1'b1; a_mat = 72'h050505050505050505; b_mat = 72'h0; end
      @(negedge clk); start = 1'b0;
      chk("R5 partial wave", c_out, expect_at(a, b, s));
      chk("R4 done timing", 162'(done), 162'(s == 7));
      chk("R4 busy timing", 162'(busy), 162'(s < 7));
    end
    fin = expect_at(a, b, 9);
    chk("R3 final product", c_out, fin);
    a_mat = 72'h111111111111111111; b_mat = 72'h222222222222222222;
    @(negedge clk);
    chk("R4 done single cycle", 162'(done), 162'd0);
    chk("R6 result held", c_out, fin);
    repeat (3) @(negedge clk);
    chk("R6 result held idle", c_out, fin);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 busy", 162'(busy), 162'd0);
    chk("R1 done", 162'(done), 162'd0);
    chk("R1 c_out", c_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", c_out, '0);
    for (int v = 0; v < NV; v++) run(VA[v], VB[v], 0);
    // R8 full-scale extremes
    run(72'h808080808080808080, 72'h7F7F7F7F7F7F7F7F7F, 0);
    // R7 start mid-run ignored
    run(VA[1], VB[1], 3);
    run(VA[4], VB[4], 7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule